// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt redirection controller. A bus master sees only two 32-bit locations in a 256-byte region: an 8-bit select pointer at offset 0x00 and a data window at offset 0x10. The select value picks what the window shows: an identification register, a version register, an arbitration register, or one 32-bit half of a 64-bit redirection entry, with one entry per interrupt input pin.

Each entry holds the routing for its pin, and the whole table is driven out on a flat bus for the delivery logic. That logic is outside this block. It feeds back two status bits per pin: it sets and clears remote-IRR with pulses, and it drives delivery status as a level. Window writes can never change either status bit. A write that leaves an entry edge-triggered clears its remote-IRR. When a write flips an entry's mask bit, the block reports that for one cycle on a pulse output with the pin index and the new mask value.

Top module: `irq_redir_regs`

## Requirements
- R1: The select register is 8 bits wide and is loaded from write data bits 7:0 by a write to offset 0x00. A read of offset 0x00 returns it in bits 7:0 with bits 31:8 zero.
- R2: With select 0x01, a window read returns NUM_PINS-1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes with select 0x01 change nothing.
- R3: With select 0x00, a window write loads a 4-bit ID from data bits 27:24, and a window read returns the ID in bits 27:24 with all other bits zero. With select 0x02, a window read returns the same value and a window write changes nothing.
- R4: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. Entry field layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger mode 15 (1 = level, 0 = edge), mask 16, destination 63:56.
- R5: A select that maps to no existing entry reads all ones through the window. This covers an index at or above NUM_PINS and selects 0x03 to 0x0F. A window write with such a select changes nothing and raises no mask pulse.
- R6: A window write to an entry leaves remote-IRR (bit 14) and delivery status (bit 12) unaffected by the written data.
- R7: After any window write (either half) that leaves an entry in edge mode (bit 15 = 0), that entry's remote-IRR is 0. This holds even when a remote-IRR set arrives in the same cycle.
- R8: After reset, every entry reads 0x0000_0000_0001_0000 (mask set, all else zero), and the select and the ID are zero.
- R9: Offsets other than 0x00 and 0x10 read as zero, and writes to them change nothing.
- R10: In the cycle after a window write that changes an entry's mask bit, mask_chg_o is 1 for one cycle, mask_pin_o gives the entry index, and mask_val_o gives the new mask. A write that leaves the mask unchanged gives no pulse.
- R11: Outside the R7 case, a pulse on rirr_set_i[p] sets remote-IRR of entry p and a pulse on rirr_clr_i[p] clears it, with set winning if both arrive together. Delivery status of entry p follows dstat_i[p] one cycle later.
- R12: table_o carries entry p in bits 64*p+63 down to 64*p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset within the register region |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| rirr_set_i | input | NUM_PINS | Per-pin remote-IRR set pulse from delivery logic |
| rirr_clr_i | input | NUM_PINS | Per-pin remote-IRR clear pulse (end of interrupt) |
| dstat_i | input | NUM_PINS | Per-pin delivery status level |
| table_o | output | 64*NUM_PINS | All redirection entries, flat |
| mask_chg_o | output | 1 | One-cycle pulse when a write flips a mask bit |
| mask_pin_o | output | $clog2(NUM_PINS) | Index of the entry whose mask changed |
| mask_val_o | output | 1 | New mask value |

## Verification
A window write to an entry and a remote-IRR set or clear from the delivery side can land on the same entry in the same clock. The bench drives rirr_set_i or rirr_clr_i in the same cycle as a window write, once with a level-mode write, where the set must survive the write, and once with an edge-mode write, where the write must clear it. The write is done to each half in turn. It also raises set and clear together with no write, where set must win. Each result is judged by reading the entry back through the window and by looking at table_o.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL  = 8'h10;

  localparam int DSTAT_BIT = 12;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {
    WIN_ID,
    WIN_VER,
    WIN_ARB,
    WIN_TBL
  } win_kind_e;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       sel_i,
  output win_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o,
  output logic             tbl_ok_o
);
  localparam logic [7:0] PINS8 = 8'(NUM_PINS);

  logic [7:0] off_sh;

  // below 0x10 the subtraction wraps, so the index lands out of range
  assign off_sh = (sel_i - SEL_TBL) >> 1;
  assign idx_o  = off_sh[IDX_W-1:0];
  assign hi_o   = sel_i[0];

  always_comb begin
    tbl_ok_o = 1'b0;
    unique case (sel_i)
      SEL_ID:  kind_o = WIN_ID;
      SEL_VER: kind_o = WIN_VER;
      SEL_ARB: kind_o = WIN_ARB;
      default: begin
        kind_o   = WIN_TBL;
        tbl_ok_o = (sel_i >= SEL_TBL) && (off_sh < PINS8);
      end
    endcase
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  input  logic        dstat_i,
  output logic [63:0] entry_o,
  output logic        mask_chg_o,
  output logic        mask_new_o
);
  logic [63:0] entry_q, entry_d;
  logic        rirr_live;

  assign rirr_live = rirr_set_i | (entry_q[RIRR_BIT] & ~rirr_clr_i);

  always_comb begin
    entry_d = entry_q;
    if (wr_lo_i) entry_d[31:0]  = wdata_i;
    if (wr_hi_i) entry_d[63:32] = wdata_i;
    entry_d[DSTAT_BIT] = dstat_i;
    entry_d[RIRR_BIT]  = ((wr_lo_i | wr_hi_i) & ~entry_d[TRIG_BIT]) ? 1'b0 : rirr_live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entry_q <= ENTRY_RST;
    else         entry_q <= entry_d;
  end

  assign entry_o    = entry_q;
  assign mask_chg_o = wr_lo_i & (wdata_i[MASK_BIT] != entry_q[MASK_BIT]);
  assign mask_new_o = wdata_i[MASK_BIT];

  assert_edge_lo_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && !wdata_i[TRIG_BIT] |=> !entry_o[RIRR_BIT]);

  assert_edge_hi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && !wr_lo_i && !entry_o[TRIG_BIT] |=> !entry_o[RIRR_BIT]);

  assert_level_keeps_rirr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && wdata_i[TRIG_BIT] && !rirr_set_i && !rirr_clr_i
    |=> entry_o[RIRR_BIT] == $past(entry_o[RIRR_BIT]));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [7:0]                   addr_i,
  input  logic                         wr_en_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [NUM_PINS-1:0]          rirr_set_i,
  input  logic [NUM_PINS-1:0]          rirr_clr_i,
  input  logic [NUM_PINS-1:0]          dstat_i,
  output logic [64*NUM_PINS-1:0]       table_o,
  output logic                         mask_chg_o,
  output logic [$clog2(NUM_PINS)-1:0]  mask_pin_o,
  output logic                         mask_val_o
);
  localparam int         IDX_W   = $clog2(NUM_PINS);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  initial begin
    if (NUM_PINS < 2 || NUM_PINS > 120) $error("NUM_PINS out of range");
  end

  logic [7:0]          sel_q;
  logic [3:0]          id_q;
  win_kind_e           kind;
  logic [IDX_W-1:0]    idx;
  logic                hi, tbl_ok;
  logic                win_wr;
  logic [63:0]         tbl [NUM_PINS];
  logic [NUM_PINS-1:0] chg, chg_val;
  logic                any_chg, pick_val;
  logic [IDX_W-1:0]    pick_pin;
  logic [63:0]         cur_entry;
  logic [31:0]         win_rd;

  irq_redir_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) i_decode (
    .sel_i    (sel_q),
    .kind_o   (kind),
    .idx_o    (idx),
    .hi_o     (hi),
    .tbl_ok_o (tbl_ok)
  );

  assign win_wr = wr_en_i && (addr_i == OFF_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFF_SEL) sel_q <= wdata_i[7:0];
      if (win_wr && kind == WIN_ID) id_q <= wdata_i[27:24];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = win_wr && (kind == WIN_TBL) && tbl_ok && (idx == IDX_W'(p));

    irq_redir_entry i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_lo_i    (hit && !hi),
      .wr_hi_i    (hit && hi),
      .wdata_i    (wdata_i),
      .rirr_set_i (rirr_set_i[p]),
      .rirr_clr_i (rirr_clr_i[p]),
      .dstat_i    (dstat_i[p]),
      .entry_o    (tbl[p]),
      .mask_chg_o (chg[p]),
      .mask_new_o (chg_val[p])
    );

    assign table_o[64*p +: 64] = tbl[p];
  end

  // at most one entry is written per cycle
  always_comb begin
    any_chg  = 1'b0;
    pick_pin = '0;
    pick_val = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (chg[i]) begin
        any_chg  = 1'b1;
        pick_pin = IDX_W'(i);
        pick_val = chg_val[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_chg_o <= 1'b0;
      mask_pin_o <= '0;
      mask_val_o <= 1'b0;
    end else begin
      mask_chg_o <= any_chg;
      mask_pin_o <= pick_pin;
      mask_val_o <= pick_val;
    end
  end

  assign cur_entry = tbl_ok ? tbl[idx] : '1;

  always_comb begin
    unique case (kind)
      WIN_ID, WIN_ARB: win_rd = {4'h0, id_q, 24'h0};
      WIN_VER:         win_rd = {8'h0, MAX_PIN, 8'h0, VERSION};
      default:         win_rd = hi ? cur_entry[63:32] : cur_entry[31:0];
    endcase
  end

  always_comb begin
    unique case (addr_i)
      OFF_SEL: rdata_o = {24'h0, sel_q};
      OFF_WIN: rdata_o = win_rd;
      default: rdata_o = '0;
    endcase
  end

  assert_ro_id_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr && (kind == WIN_VER || kind == WIN_ARB) |=> $stable(id_q));

  assert_oob_no_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr && kind == WIN_TBL && !tbl_ok |=> !mask_chg_o);

  assert_pulse_matches_table_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> tbl[mask_pin_o][MASK_BIT] == mask_val_o);

  assert_pulse_needs_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_wr |=> !mask_chg_o);
endmodule

// File: tb/test_irq_redir_regs.sv
module test_irq_redir_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      addr = '0;
  logic            wr_en = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   rset = '0, rclr = '0, dstat = '0;
  logic [64*NP-1:0] tbl;
  logic            mchg, mval;
  logic [IW-1:0]   mpin;

  int n_run = 0;
  int n_fail = 0;

  irq_redir_regs #(.NUM_PINS(NP), .VERSION(8'h11)) i_irq_redir_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .rirr_set_i(rset), .rirr_clr_i(rclr), .dstat_i(dstat),
    .table_o(tbl), .mask_chg_o(mchg), .mask_pin_o(mpin), .mask_val_o(mval)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                        input logic [NP-1:0] s = '0, input logic [NP-1:0] c = '0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rset = s; rclr = c;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rset = '0; rclr = '0;
  endtask

  task automatic pulse_st(input logic [NP-1:0] s, input logic [NP-1:0] c);
    @(negedge clk);
    rset = s; rclr = c;
    @(posedge clk);
    #1;
    rset = '0; rclr = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    d = rdata;
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(8'h10, d);
  endtask

  function automatic logic [63:0] ent(input int p);
    return tbl[64*p +: 64];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h00, d);
    chk("R1 select reset", d, 0);
    bus_rd(8'h10, d);
    chk("R8 id reset", d, 0);
    for (int p = 0; p < NP; p++) chk("R8 entry reset", ent(p), 64'h0000_0000_0001_0000);
    chk("R10 no pulse at reset", mchg, 0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    bus_wr(8'h00, 32'hABCD_12F5);
    bus_rd(8'h00, d);
    chk("R1 select 8 bits", d, 32'h0000_00F5);
  endtask

  task automatic t_version;
    logic [31:0] d;
    win_rd(8'h01, d);
    chk("R2 version read", d, 32'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);
    chk("R2 version write ignored", d, 32'h0017_0011);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h10, d);
    chk("R2 version write left id", d, 32'h0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);
    chk("R3 id load", d, 32'h0F00_0000);
    win_rd(8'h02, d);
    chk("R3 arb reads id", d, 32'h0F00_0000);
    bus_wr(8'h10, 32'h0);
    win_rd(8'h00, d);
    chk("R3 arb write ignored", d, 32'h0F00_0000);
    bus_wr(8'h10, 32'h0500_0000);
    bus_rd(8'h10, d);
    chk("R3 id reload", d, 32'h0500_0000);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    bus_wr(8'h00, 32'h1A);
    bus_wr(8'h10, 32'h0000_D031);
    chk("R10 pulse on unmask", mchg, 1);
    chk("R10 pulse pin", 64'(mpin), 5);
    chk("R10 pulse value", mval, 0);
    chk("R6 status bits not written", ent(5), 64'h0000_0000_0000_8031);
    bus_wr(8'h00, 32'h1B);
    chk("R10 pulse one cycle", mchg, 0);
    bus_wr(8'h10, 32'hA500_0000);
    chk("R10 no pulse on high write", mchg, 0);
    chk("R12 entry 5 in table", ent(5), 64'hA500_0000_0000_8031);
    bus_rd(8'h10, d);
    chk("R4 odd select high half", d, 32'hA500_0000);
    win_rd(8'h1A, d);
    chk("R4 even select low half", d, 32'h0000_8031);
    bus_wr(8'h10, 32'h0000_8032);
    chk("R10 no pulse mask unchanged", mchg, 0);
    chk("R4 entry 4 untouched", ent(4), 64'h0000_0000_0001_0000);
    bus_wr(8'h10, 32'h0001_8032);
    chk("R10 pulse on mask", mchg, 1);
    chk("R10 pulse mask value", mval, 1);
    bus_wr(8'h10, 32'h0000_8031);
    chk("R10 pulse on unmask again", mval, 0);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    logic [64*NP-1:0] snap;
    snap = tbl;
    win_rd(8'h40, d);
    chk("R5 index at pin count reads ones", d, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h0000_0000);
    chk("R5 oob write no pulse", mchg, 0);
    chk("R5 oob write table unchanged", 64'(tbl == snap), 1);
    win_rd(8'h05, d);
    chk("R5 low select reads ones", d, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h0);
    chk("R5 low select write table unchanged", 64'(tbl == snap), 1);
  endtask

  task automatic t_other;
    logic [31:0] d;
    logic [64*NP-1:0] snap;
    bus_wr(8'h00, 32'h1A);
    snap = tbl;
    bus_rd(8'h04, d);
    chk("R9 offset 0x04 reads zero", d, 0);
    bus_rd(8'h20, d);
    chk("R9 offset 0x20 reads zero", d, 0);
    bus_wr(8'h20, 32'h0001_0000);
    bus_wr(8'h14, 32'h0000_0077);
    bus_rd(8'h00, d);
    chk("R9 select unchanged", d, 32'h1A);
    chk("R9 table unchanged", 64'(tbl == snap), 1);
  endtask

  task automatic t_status;
    logic [31:0] d;
    bus_wr(8'h00, 32'h1A);
    pulse_st(NP'(1) << 5, '0);
    bus_rd(8'h10, d);
    chk("R11 remote-IRR set", 64'(d[14]), 1);
    bus_wr(8'h10, 32'h0000_8031);
    chk("R6 level write keeps remote-IRR", 64'(ent(5) >> 14) & 1, 1);
    @(negedge clk) dstat[5] = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 delivery status follows", 64'(ent(5) >> 12) & 1, 1);
    bus_wr(8'h10, 32'h0000_8031);
    chk("R6 write keeps delivery status", 64'(ent(5) >> 12) & 1, 1);
    bus_wr(8'h10, 32'h0000_0031);
    chk("R7 edge write clears remote-IRR", 64'(ent(5) >> 14) & 1, 0);
    chk("R6 edge write keeps delivery status", 64'(ent(5) >> 12) & 1, 1);
    @(negedge clk) dstat[5] = 1'b0;
    bus_wr(8'h10, 32'h0000_8031);
    pulse_st(NP'(1) << 5, '0);
    pulse_st('0, NP'(1) << 5);
    chk("R11 remote-IRR clear", 64'(ent(5) >> 14) & 1, 0);
    chk("R11 delivery status drops", 64'(ent(5) >> 12) & 1, 0);
  endtask

  task automatic t_same_cycle;
    bus_wr(8'h00, 32'h1E);
    bus_wr(8'h10, 32'h0000_8040, NP'(1) << 7);
    chk("R11 set with level write", 64'(ent(7) >> 14) & 1, 1);
    chk("R10 pulse pin 7", 64'(mpin), 7);
    bus_wr(8'h10, 32'h0000_0040, NP'(1) << 7);
    chk("R7 edge write beats set", 64'(ent(7) >> 14) & 1, 0);
    pulse_st(NP'(1) << 7, NP'(1) << 7);
    chk("R11 set wins over clear", 64'(ent(7) >> 14) & 1, 1);
    bus_wr(8'h00, 32'h1F);
    bus_wr(8'h10, 32'h3C00_0000);
    chk("R7 high write on edge entry clears", 64'(ent(7) >> 14) & 1, 0);
    chk("R12 entry 7 in table", ent(7), 64'h3C00_0000_0000_0040);
    bus_wr(8'h00, 32'h1E);
    bus_wr(8'h10, 32'h0000_8040, '0, NP'(1) << 7);
    pulse_st(NP'(1) << 7, '0);
    bus_wr(8'h10, 32'h0000_8041, '0, NP'(1) << 7);
    chk("R11 clear with level write", 64'(ent(7) >> 14) & 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_version();
    t_id();
    t_entry();
    t_oob();
    t_other();
    t_status();
    t_same_cycle();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule